// File: doc/BRIEF.md
# System Reset Source Aggregator

This block merges every reason a microcontroller may need a system reset into one active-low system reset. The reasons are power-on, the external reset pin, two watchdog requests, a software request, and entry into standby or deep-sleep mode. Each of the two low-power entry sources counts only when its own option input allows it. Any active source pulls the reset low at once, without waiting for a clock. Release is brought back into the system clock domain through a two-flop synchroniser and then stretched by a counter. As a result, the reset stays low for a fixed minimum number of cycles after the last source goes away.

The system reset drives the core and peripheral resets. A separate reset for the debug controller and the backup domain is driven by power-on alone. That reset therefore survives every other kind of reset. A sticky per-source cause register records which sources have fired since it was last cleared, so software can find out why the chip restarted. Software clears it with a write-one-to-clear mask.

Top module: `reset_gather`

## Requirements
- R1: While any qualified source is active (porN low, pinRstN low, wdgWinReq, wdgFreeReq or swRstReq high, or a qualified low-power entry), sysRstN is low in that same cycle, without waiting for a clock edge.
- R2: A high stbyEnter resets the system only when optStbyNoRst is 0. When optStbyNoRst is 1, standby entry leaves sysRstN and causeFlags[5] unchanged.
- R3: A high dslpEnter resets the system only when optDslpNoRst is 0. When optDslpNoRst is 1, deep-sleep entry leaves sysRstN and causeFlags[6] unchanged.
- R4: coreRstN and periRstN always equal sysRstN. dbgRstN and bkpRstN stay high through resets from any source other than power-on.
- R5: While porN is low, all five reset outputs are low. dbgRstN and bkpRstN go high on the 2nd rising clock edge after porN rises.
- R6: sysRstN goes high on the 18th rising clock edge after the last active source goes inactive: 2 synchroniser stages plus 16 stretch cycles.
- R7: causeFlags is sticky and is set on the clock edge where its source is sampled active. The bit positions are: 0 power, 1 pin, 2 window watchdog, 3 free watchdog, 4 software, 5 qualified standby, 6 qualified deep-sleep.
- R8: A 1 in causeClr clears the matching flag at the next edge. If a source sets a flag in the same cycle that causeClr clears it, the set wins.
- R9: While porN is low, causeFlags reads 7'b0000001. Power-on clears every other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset from the supply monitor, active low |
| pinRstN | input | 1 | External reset pin, active low |
| wdgWinReq | input | 1 | Window watchdog reset request |
| wdgFreeReq | input | 1 | Free-running watchdog reset request |
| swRstReq | input | 1 | Software reset request bit |
| stbyEnter | input | 1 | Standby-entry indication |
| dslpEnter | input | 1 | Deep-sleep-entry indication |
| optStbyNoRst | input | 1 | Option: 1 means standby entry does not reset |
| optDslpNoRst | input | 1 | Option: 1 means deep-sleep entry does not reset |
| causeClr | input | 7 | Write-one-to-clear mask for causeFlags |
| sysRstN | output | 1 | Synchronised system reset, active low |
| coreRstN | output | 1 | Core reset, active low |
| periRstN | output | 1 | Peripheral reset, active low |
| dbgRstN | output | 1 | Debug controller reset, power-on only, active low |
| bkpRstN | output | 1 | Backup domain reset, power-on only, active low |
| causeFlags | output | 7 | Sticky reset-cause flags |

## Verification
A wrong synchroniser or stretch counter shows on the first release after any source. sysRstN then rises one or more edges away from the 18th edge, and a per-cycle reference model catches this on that exact edge. A wrong source qualification or flag mask shows at the next edge, as an unexpected low sysRstN or a wrong causeFlags bit. A debug or backup reset wrongly tied to the system reset drops dbgRstN during the first pin or watchdog reset.

// File: rtl/reset_gather_pkg.sv
package reset_gather_pkg;

  localparam int NSRC = 7;

  typedef enum int {
    SRC_POWER = 0,
    SRC_PIN   = 1,
    SRC_WWIN  = 2,
    SRC_WFREE = 3,
    SRC_SOFT  = 4,
    SRC_STBY  = 5,
    SRC_DSLP  = 6
  } rstSrc_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic            holdRst;  // some qualified source is active now
    logic [NSRC-1:0] setMask;  // flags to set at the next edge
    logic [NSRC-1:0] clrMask;  // flags to clear at the next edge
  } rstStrobe_t;

endpackage

// File: rtl/reset_gather_sync.sv
module reset_gather_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic relN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign relN = chain[STAGES-1];
endmodule

// File: rtl/reset_gather_ctrl.sv
module reset_gather_ctrl
  import reset_gather_pkg::*;
(
  input  logic            porN,
  input  logic            pinRstN,
  input  logic            wdgWinReq,
  input  logic            wdgFreeReq,
  input  logic            swRstReq,
  input  logic            stbyEnter,
  input  logic            dslpEnter,
  input  logic            optStbyNoRst,
  input  logic            optDslpNoRst,
  input  logic [NSRC-1:0] causeClr,
  output rstStrobe_t      strobe
);
  logic stbyHit;
  logic dslpHit;

  always_comb begin
    // low-power entries count only when their option bit is cleared
    stbyHit = stbyEnter & ~optStbyNoRst;
    dslpHit = dslpEnter & ~optDslpNoRst;

    strobe.setMask            = '0;
    strobe.setMask[SRC_PIN]   = ~pinRstN;
    strobe.setMask[SRC_WWIN]  = wdgWinReq;
    strobe.setMask[SRC_WFREE] = wdgFreeReq;
    strobe.setMask[SRC_SOFT]  = swRstReq;
    strobe.setMask[SRC_STBY]  = stbyHit;
    strobe.setMask[SRC_DSLP]  = dslpHit;

    strobe.clrMask = causeClr;
    strobe.holdRst = ~porN | (|strobe.setMask);
  end
endmodule

// File: rtl/reset_gather_dp.sv
module reset_gather_dp
  import reset_gather_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 16
) (
  input  logic            clk,
  input  logic            porN,
  input  rstStrobe_t      strobe,
  output logic            sysRstN,
  output logic            dbgRstN,
  output logic [NSRC-1:0] causeFlags
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(STRETCH);
  localparam logic [NSRC-1:0] POR_FLAGS = NSRC'(1) << SRC_POWER;

  logic holdN;
  logic sysRel;
  logic [CW-1:0] stretchCnt;
  logic [NSRC-1:0] flagsQ;

  assign holdN = ~strobe.holdRst;

  reset_gather_sync #(.STAGES(SYNC_STAGES)) sysSync_i (
    .clk  (clk),
    .arstN(holdN),
    .relN (sysRel)
  );

  reset_gather_sync #(.STAGES(SYNC_STAGES)) porSync_i (
    .clk  (clk),
    .arstN(porN),
    .relN (dbgRstN)
  );

  always_ff @(posedge clk or negedge holdN) begin
    if (!holdN)                              stretchCnt <= '0;
    else if (sysRel && stretchCnt != CNT_DONE) stretchCnt <= stretchCnt + 1'b1;
  end

  assign sysRstN = (stretchCnt == CNT_DONE);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) flagsQ <= POR_FLAGS;
    else       flagsQ <= (flagsQ & ~strobe.clrMask) | strobe.setMask;
  end

  assign causeFlags = flagsQ;

  // ---- assertions ----
  logic [7:0] lowRun;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)        lowRun <= '0;
    else if (sysRstN) lowRun <= '0;
    else if (lowRun != 8'hFF) lowRun <= lowRun + 1'b1;
  end

  p_stretch_min_r6: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRstN) |-> (lowRun >= 8'(STRETCH)));

  p_dbg_hold_r5: assert property (@(posedge clk) disable iff (!porN)
    $past(dbgRstN) |-> dbgRstN);

  p_por_flags_r9: assert property (@(posedge clk)
    $rose(porN) |-> (causeFlags == POR_FLAGS));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!porN)
    ((causeFlags & $past(causeFlags & ~strobe.clrMask)) == $past(causeFlags & ~strobe.clrMask)));

  for (genvar k = 0; k < NSRC; k++) begin : g_clrChk
    p_clear_r8: assert property (@(posedge clk) disable iff (!porN)
      $past(strobe.clrMask[k] && !strobe.setMask[k]) |-> !causeFlags[k]);
    p_set_r7: assert property (@(posedge clk) disable iff (!porN)
      $past(strobe.setMask[k]) |-> causeFlags[k]);
  end
endmodule

// File: rtl/reset_gather.sv
module reset_gather
  import reset_gather_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 16
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            pinRstN,
  input  logic            wdgWinReq,
  input  logic            wdgFreeReq,
  input  logic            swRstReq,
  input  logic            stbyEnter,
  input  logic            dslpEnter,
  input  logic            optStbyNoRst,
  input  logic            optDslpNoRst,
  input  logic [NSRC-1:0] causeClr,
  output logic            sysRstN,
  output logic            coreRstN,
  output logic            periRstN,
  output logic            dbgRstN,
  output logic            bkpRstN,
  output logic [NSRC-1:0] causeFlags
);
  rstStrobe_t strobe;
  logic porRelN;

  reset_gather_ctrl ctrl_i (
    .porN        (porN),
    .pinRstN     (pinRstN),
    .wdgWinReq   (wdgWinReq),
    .wdgFreeReq  (wdgFreeReq),
    .swRstReq    (swRstReq),
    .stbyEnter   (stbyEnter),
    .dslpEnter   (dslpEnter),
    .optStbyNoRst(optStbyNoRst),
    .optDslpNoRst(optDslpNoRst),
    .causeClr    (causeClr),
    .strobe      (strobe)
  );

  reset_gather_dp #(.SYNC_STAGES(SYNC_STAGES), .STRETCH(STRETCH)) dp_i (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .sysRstN   (sysRstN),
    .dbgRstN   (porRelN),
    .causeFlags(causeFlags)
  );

  assign coreRstN = sysRstN;
  assign periRstN = sysRstN;
  assign dbgRstN  = porRelN;
  assign bkpRstN  = porRelN;

  // ---- assertions ----
  p_async_hold_r1: assert property (@(posedge clk)
    (!porN || !pinRstN || wdgWinReq || wdgFreeReq || swRstReq ||
     (stbyEnter && !optStbyNoRst) || (dslpEnter && !optDslpNoRst)) |-> !sysRstN);

  p_stby_gate_r2: assert property (@(posedge clk) disable iff (!porN)
    ($past(sysRstN) && pinRstN && !wdgWinReq && !wdgFreeReq && !swRstReq &&
     !(dslpEnter && !optDslpNoRst) && stbyEnter && optStbyNoRst) |-> sysRstN);

  p_dslp_gate_r3: assert property (@(posedge clk) disable iff (!porN)
    ($past(sysRstN) && pinRstN && !wdgWinReq && !wdgFreeReq && !swRstReq &&
     !(stbyEnter && !optStbyNoRst) && dslpEnter && optDslpNoRst) |-> sysRstN);

  p_domain_split_r4: assert property (@(posedge clk) disable iff (!porN)
    (!sysRstN && $past(dbgRstN)) |-> bkpRstN);
endmodule

// File: tb/reset_gather_tb_top.sv
module reset_gather_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int REL_EDGES = 18;

  logic clk = 1'b0;
  logic porN = 1'b0, pinRstN = 1'b1;
  logic wdgWinReq = 1'b0, wdgFreeReq = 1'b0, swRstReq = 1'b0;
  logic stbyEnter = 1'b0, dslpEnter = 1'b0;
  logic optStbyNoRst = 1'b1, optDslpNoRst = 1'b1;
  logic [6:0] causeClr = '0;
  logic sysRstN, coreRstN, periRstN, dbgRstN, bkpRstN;
  logic [6:0] causeFlags;

  int total = 0, bad = 0;
  int relEdges = 0, porEdges = 0;
  logic [6:0] mFlags = 7'h01;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  reset_gather dut_i (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .wdgWinReq(wdgWinReq),
    .wdgFreeReq(wdgFreeReq), .swRstReq(swRstReq), .stbyEnter(stbyEnter),
    .dslpEnter(dslpEnter), .optStbyNoRst(optStbyNoRst), .optDslpNoRst(optDslpNoRst),
    .causeClr(causeClr), .sysRstN(sysRstN), .coreRstN(coreRstN), .periRstN(periRstN),
    .dbgRstN(dbgRstN), .bkpRstN(bkpRstN), .causeFlags(causeFlags)
  );

  function automatic logic [6:0] srcSet();
    logic [6:0] s;
    s = '0;
    s[1] = !pinRstN;
    s[2] = wdgWinReq;
    s[3] = wdgFreeReq;
    s[4] = swRstReq;
    s[5] = stbyEnter && !optStbyNoRst;
    s[6] = dslpEnter && !optDslpNoRst;
    return s;
  endfunction

  function automatic bit anyActive();
    return !porN || (srcSet() != 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated every edge and compared before the next one
  always @(posedge clk) begin
    if (!porN) begin mFlags = 7'h01; porEdges = 0; end
    else begin
      mFlags = (mFlags & ~causeClr) | srcSet();
      if (porEdges < 100) porEdges++;
    end
    if (anyActive()) relEdges = 0;
    else if (relEdges < 1000) relEdges++;
    #(HALF - 1);
    chk("R1/R6 sysRstN", sysRstN, (!anyActive() && relEdges >= REL_EDGES));
    chk("R4 coreRstN", coreRstN, sysRstN);
    chk("R4 periRstN", periRstN, sysRstN);
    chk("R5 dbgRstN", dbgRstN, (porN && porEdges >= 2));
    chk("R5 bkpRstN", bkpRstN, (porN && porEdges >= 2));
    chk("R7 causeFlags", causeFlags, porN ? mFlags : 7'h01);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe();
    @(posedge clk); #(HALF - 2);
  endtask

  initial begin
    cyc(3);
    probe();
    chk("R5 reset state sys", sysRstN, 0);
    chk("R5 reset state dbg", dbgRstN, 0);
    chk("R9 por flags", causeFlags, 7'h01);
    @(negedge clk) porN = 1'b1;
    cyc(REL_EDGES + 2);
    chk("R6 released", sysRstN, 1);

    // pin reset: debug domain must stay up
    @(negedge clk) pinRstN = 1'b0;
    #1 chk("R1 async pin", sysRstN, 0);
    cyc(3);
    chk("R4 dbg kept", dbgRstN, 1);
    pinRstN = 1'b1;
    cyc(REL_EDGES - 1); #1;
    chk("R6 still low edge17", sysRstN, 0);
    cyc(1); #1;
    chk("R6 high edge18", sysRstN, 1);
    chk("R7 pin flag", causeFlags, 7'h03);

    // clear pin flag, then power flag
    @(negedge clk) causeClr = 7'h02;
    @(negedge clk) causeClr = 7'h01;
    @(negedge clk) causeClr = 7'h00;
    chk("R8 cleared", causeFlags, 7'h00);

    // standby with option set: no reset
    @(negedge clk) begin optStbyNoRst = 1'b1; stbyEnter = 1'b1; end
    #1 chk("R2 gated sys", sysRstN, 1);
    @(negedge clk) stbyEnter = 1'b0;
    chk("R2 gated flag", causeFlags, 7'h00);
    @(negedge clk) begin optStbyNoRst = 1'b0; stbyEnter = 1'b1; end
    #1 chk("R2 reset sys", sysRstN, 0);
    @(negedge clk) stbyEnter = 1'b0;
    chk("R2 flag", causeFlags, 7'h20);
    cyc(REL_EDGES + 1);

    // deep-sleep
    @(negedge clk) begin optDslpNoRst = 1'b1; dslpEnter = 1'b1; end
    #1 chk("R3 gated sys", sysRstN, 1);
    @(negedge clk) dslpEnter = 1'b0;
    chk("R3 gated flag", causeFlags, 7'h20);
    @(negedge clk) begin optDslpNoRst = 1'b0; dslpEnter = 1'b1; end
    #1 chk("R3 reset sys", sysRstN, 0);
    @(negedge clk) dslpEnter = 1'b0;
    chk("R3 flag", causeFlags, 7'h60);
    cyc(5);

    // watchdogs and software, overlapping so release follows the last one
    @(negedge clk) wdgWinReq = 1'b1;
    cyc(2); wdgFreeReq = 1'b1; wdgWinReq = 1'b0;
    cyc(2); swRstReq = 1'b1; wdgFreeReq = 1'b0;
    cyc(1); swRstReq = 1'b0;
    chk("R7 wdg+sw flags", causeFlags, 7'h7C);
    cyc(REL_EDGES); #1;
    chk("R6 after last source", sysRstN, 1);

    // set wins over clear in the same cycle
    @(negedge clk) begin swRstReq = 1'b1; causeClr = 7'h10; end
    @(negedge clk) begin swRstReq = 1'b0; causeClr = 7'h00; end
    chk("R8 set beats clear", causeFlags[4], 1);
    @(negedge clk) causeClr = 7'h10;
    @(negedge clk) causeClr = 7'h00;
    chk("R8 clear sw", causeFlags[4], 0);
    cyc(REL_EDGES + 1);

    // power-on mid-run
    @(negedge clk) porN = 1'b0;
    #1;
    chk("R9 por clears flags", causeFlags, 7'h01);
    chk("R5 por dbg", dbgRstN, 0);
    chk("R5 por bkp", bkpRstN, 0);
    cyc(2); porN = 1'b1;
    cyc(1); #1 chk("R5 dbg edge1", dbgRstN, 0);
    cyc(1); #1 chk("R5 dbg edge2", dbgRstN, 1);
    cyc(REL_EDGES);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule